// File: doc/BRIEF.md
# Algebraic Word Right Shift Unit

This execution unit sits in a 64-bit integer datapath. It takes the low 32 bits of a source operand as a signed word and shifts it right arithmetically by an amount taken from the low six bits of a second operand. The shifted word is sign-extended to 64 bits. Amounts of 32 or more saturate the word to its sign. Alongside the result it produces a carry flag, which is set only when a negative word loses at least one 1-bit off its low end. It also produces a 4-bit signed condition field for record-form operations. The field compares the result against zero and carries along the incoming summary-overflow bit.

The unit only supplies values and write enables. The carry write enable is raised for every operation. The condition write enable is raised only when the record flag is set. Arbitration of the flag writebacks belongs to the surrounding pipeline. With the default configuration, every output is captured in one register stage, so a result appears one cycle after its valid input. When no operation is presented, the registered values hold.

Top module: `sraw_unit`

## Requirements
- R1: Only the low 6 bits of `amt_i` set the shift amount (0 to 63). Bits 63:6 of `amt_i` have no effect on any output.
- R2: Only `src_i[31:0]` takes part, as a signed word. For an amount n from 1 to 31, `result_o[31:0]` equals that word shifted right by n with bit 31 copied into the vacated positions. Bits 63:32 of `src_i` have no effect.
- R3: For every valid result, `result_o[63:32]` equals 32 copies of `result_o[31]`.
- R4: An amount of 0 gives `result_o[31:0] = src_i[31:0]` (sign-extended) and `ca_o = 0`.
- R5: For an amount from 1 to 31, `ca_o` is 1 exactly when `src_i[31]` is 1 and at least one of the n lowest bits of the word is 1.
- R6: For an amount from 32 to 63, a negative word gives `result_o` of all ones with `ca_o = 1`, and a non-negative word gives 0 with `ca_o = 0`.
- R7: `ca_we_o` is 1 in every cycle in which `out_valid` is 1, whatever the record flag.
- R8: When `rec_i` is 1, `cr_we_o` is 1 and `cr_o` is {lt, gt, eq, so} on bits 3 down to 0. Here lt means the 64-bit result is negative, gt means it is positive, and eq means it is zero, so exactly one of bits 3:1 is set. When `rec_i` is 0, `cr_we_o` is 0 and `cr_o` is 0.
- R9: `out_valid` follows `in_valid` one clock later. While `in_valid` is 0, `result_o`, `ca_o` and `cr_o` hold the last captured values, and `ca_we_o` and `cr_we_o` are 0.
- R10: `so_i` affects only `cr_o[0]`, which copies it on record-form operations. The result and the carry do not depend on it.
- R11: After reset, `out_valid`, `ca_we_o` and `cr_we_o` are 0, and `result_o`, `ca_o` and `cr_o` are 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operation present this cycle |
| src_i | input | 64 | Source operand; low word is shifted |
| amt_i | input | 64 | Shift operand; low 6 bits are the amount |
| rec_i | input | 1 | Record flag: request a condition field |
| so_i | input | 1 | Current summary-overflow bit |
| out_valid | output | 1 | Outputs carry a new result |
| result_o | output | 64 | Sign-extended shifted word |
| ca_o | output | 1 | Carry flag value |
| ca_we_o | output | 1 | Carry write enable |
| cr_o | output | 4 | Condition field {lt, gt, eq, so} |
| cr_we_o | output | 1 | Condition write enable |

## Verification
The assertions watch the port-level invariants on every cycle. These are the one-cycle valid latency, the carry write enable paired with each valid output, and the upper result half mirroring bit 31. They also cover the single lt/gt/eq indication with the summary-overflow copy, a zero amount clearing the carry, and a saturated negative word giving all ones with carry. The exact shifted values, the carry for partial shifts that drop only zeros versus those that drop a one, and the fact that the upper operand bits are ignored can only be shown by the bench. It sweeps every amount from 0 to 63 over extreme and mixed source words, with junk in the ignored bits.

// File: rtl/sraw_pkg.sv
package sraw_pkg;

  // Condition field, most significant first: lt, gt, eq, so.
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_field_t;

  localparam int COND_W = 4;

endpackage

// File: rtl/sraw_shift_core.sv
module sraw_shift_core #(
  parameter int WORD_W = 32,
  parameter int AMT_W  = $clog2(WORD_W) + 1
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic [WORD_W-1:0] word_o
);

  localparam int STAGES = AMT_W - 1;

  logic [WORD_W-1:0] stage [STAGES+1];
  logic              sat;

  assign stage[0] = word_i;

  // Logarithmic arithmetic shifter: stage k shifts by 2**k when amt bit k is set.
  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      localparam int DIST = 1 << k;
      always_comb begin
        if (amt_i[k]) begin
          stage[k+1] = {{DIST{stage[k][WORD_W-1]}}, stage[k][WORD_W-1:DIST]};
        end else begin
          stage[k+1] = stage[k];
        end
      end
    end
  endgenerate

  // The top amount bit means the shift covers the whole word: saturate to the sign.
  assign sat = amt_i[AMT_W-1];

  always_comb begin
    if (sat) begin
      word_o = {WORD_W{word_i[WORD_W-1]}};
    end else begin
      word_o = stage[STAGES];
    end
  end

endmodule

// File: rtl/sraw_carry_det.sv
module sraw_carry_det #(
  parameter int WORD_W = 32,
  parameter int AMT_W  = $clog2(WORD_W) + 1
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic              carry_o
);

  logic [WORD_W-1:0] lost_mask;
  logic              any_lost;

  // Bit i leaves the word when the amount exceeds i.
  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_mask
      assign lost_mask[i] = (amt_i > AMT_W'(i));
    end
  endgenerate

  assign any_lost = |(word_i & lost_mask);

  // A negative word that loses a one-bit is the only carry case.
  assign carry_o = word_i[WORD_W-1] & any_lost;

endmodule

// File: rtl/sraw_cond_gen.sv
module sraw_cond_gen
  import sraw_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              rec_i,
  input  logic              so_i,
  output cond_field_t       cond_o
);

  logic is_neg;
  logic is_zero;

  assign is_neg  = res_i[DATA_W-1];
  assign is_zero = (res_i == '0);

  always_comb begin
    cond_o = '0;
    if (rec_i) begin
      cond_o.lt = is_neg;
      cond_o.gt = ~is_neg & ~is_zero;
      cond_o.eq = is_zero;
      cond_o.so = so_i;
    end
  end

endmodule

// File: rtl/sraw_unit.sv
module sraw_unit
  import sraw_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int WORD_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] amt_i,
  input  logic              rec_i,
  input  logic              so_i,
  output logic              out_valid,
  output logic [DATA_W-1:0] result_o,
  output logic              ca_o,
  output logic              ca_we_o,
  output logic [COND_W-1:0] cr_o,
  output logic              cr_we_o
);

  localparam int AMT_W = $clog2(WORD_W) + 1;
  localparam int EXT_W = DATA_W - WORD_W;

  logic [WORD_W-1:0] word_in;
  logic [AMT_W-1:0]  amt;
  logic [WORD_W-1:0] word_sh;
  logic [DATA_W-1:0] res_c;
  logic              ca_c;
  cond_field_t       cond_c;
  logic              unused_hi;

  assign word_in   = src_i[WORD_W-1:0];
  assign amt       = amt_i[AMT_W-1:0];
  assign unused_hi = ^{src_i[DATA_W-1:WORD_W], amt_i[DATA_W-1:AMT_W]};

  sraw_shift_core #(.WORD_W(WORD_W), .AMT_W(AMT_W)) u_shift (
    .word_i (word_in),
    .amt_i  (amt),
    .word_o (word_sh)
  );

  sraw_carry_det #(.WORD_W(WORD_W), .AMT_W(AMT_W)) u_carry (
    .word_i  (word_in),
    .amt_i   (amt),
    .carry_o (ca_c)
  );

  assign res_c = {{EXT_W{word_sh[WORD_W-1]}}, word_sh};

  sraw_cond_gen #(.DATA_W(DATA_W)) u_cond (
    .res_i  (res_c),
    .rec_i  (rec_i),
    .so_i   (so_i),
    .cond_o (cond_c)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic              vld_d,  vld_q;
      logic [DATA_W-1:0] res_d,  res_q;
      logic              ca_d,   ca_q;
      logic [COND_W-1:0] cr_d,   cr_q;
      logic              crwe_d, crwe_q;

      // Next state: data loads under the valid enable, enables track each op.
      always_comb begin
        vld_d  = in_valid;
        crwe_d = in_valid & rec_i;
        res_d  = res_q;
        ca_d   = ca_q;
        cr_d   = cr_q;
        if (in_valid) begin
          res_d = res_c;
          ca_d  = ca_c;
          cr_d  = cond_c;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          res_q  <= '0;
          ca_q   <= 1'b0;
          cr_q   <= '0;
          crwe_q <= 1'b0;
        end else begin
          vld_q  <= vld_d;
          res_q  <= res_d;
          ca_q   <= ca_d;
          cr_q   <= cr_d;
          crwe_q <= crwe_d;
        end
      end

      assign out_valid = vld_q;
      assign result_o  = res_q;
      assign ca_o      = ca_q;
      assign ca_we_o   = vld_q;
      assign cr_o      = cr_q;
      assign cr_we_o   = crwe_q;

      assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !cr_we_o && $stable(result_o) && $stable(ca_o)));
      assert_zero_amt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && amt_i[AMT_W-1:0] == '0) |=>
          (!ca_o && result_o[WORD_W-1:0] == $past(src_i[WORD_W-1:0])));
      assert_sat_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && amt_i[AMT_W-1] && src_i[WORD_W-1]) |=> (ca_o && (&result_o)));
      assert_so_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rec_i) |=> (cr_we_o && cr_o[0] == $past(so_i)));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign result_o  = res_c;
      assign ca_o      = ca_c;
      assign ca_we_o   = in_valid;
      assign cr_o      = cond_c;
      assign cr_we_o   = in_valid & rec_i;
    end
  endgenerate

  assert_ca_every_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ca_we_o == out_valid);
  assert_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (result_o[DATA_W-1:WORD_W] == {EXT_W{result_o[WORD_W-1]}}));
  assert_cr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we_o |-> ($countones(cr_o[COND_W-1:1]) == 1 && out_valid));

endmodule

// File: tb/sraw_unit_bench.sv
module sraw_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] src_i;
  logic [63:0] amt_i;
  logic        rec_i;
  logic        so_i;
  logic        out_valid;
  logic [63:0] result_o;
  logic        ca_o;
  logic        ca_we_o;
  logic [3:0]  cr_o;
  logic        cr_we_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sraw_unit u_sraw_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src_i     (src_i),
    .amt_i     (amt_i),
    .rec_i     (rec_i),
    .so_i      (so_i),
    .out_valid (out_valid),
    .result_o  (result_o),
    .ca_o      (ca_o),
    .ca_we_o   (ca_we_o),
    .cr_o      (cr_o),
    .cr_we_o   (cr_we_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Returns {carry, result}.
  function automatic logic [64:0] model(input logic [63:0] s, input logic [63:0] a);
    int unsigned       n = int'(a[5:0]);
    logic signed [31:0] w = s[31:0];
    logic signed [31:0] r;
    logic [31:0]        m;
    logic               c;
    if (n == 0) begin
      r = w;
      c = 1'b0;
    end else if (n < 32) begin
      r = w >>> n;
      m = (32'h1 << n) - 32'h1;
      c = w[31] && ((s[31:0] & m) != 32'h0);
    end else begin
      r = w[31] ? -32'sd1 : 32'sd0;
      c = w[31];
    end
    return {c, {{32{r[31]}}, r}};
  endfunction

  // Called at a falling edge; applies one op and checks it one edge later.
  task automatic op(input string grp, input logic [63:0] s, input logic [63:0] a,
                    input logic rec, input logic so);
    logic [64:0] e;
    logic [63:0] er;
    logic [3:0]  ecr;
    int unsigned n;
    string       rt;
    string       ct;
    e   = model(s, a);
    er  = e[63:0];
    n   = int'(a[5:0]);
    ecr = rec ? {er[63], (!er[63] && er != 0), (er == 0), so} : 4'h0;
    rt  = (n == 0) ? "R4" : ((n >= 32) ? "R6" : "R2");
    ct  = (n == 0) ? "R4" : ((n >= 32) ? "R6" : "R5");
    in_valid = 1'b1; src_i = s; amt_i = a; rec_i = rec; so_i = so;
    @(negedge clk);
    chk({grp, " R9 out_valid"}, {63'h0, out_valid}, 64'h1);
    chk({grp, " ", rt, " result"}, result_o, er);
    chk({grp, " R3 sign extension"}, result_o[63:32], {32{result_o[31]}});
    chk({grp, " ", ct, " carry"}, {63'h0, ca_o}, {63'h0, e[64]});
    chk({grp, " R7 carry we"}, {63'h0, ca_we_o}, 64'h1);
    chk({grp, " R8 cond we"}, {63'h0, cr_we_o}, {63'h0, rec});
    chk({grp, " R8 cond lt/gt/eq"}, {60'h0, cr_o[3:1], 1'b0}, {60'h0, ecr[3:1], 1'b0});
    chk({grp, " R10 cond so"}, {63'h0, cr_o[0]}, {63'h0, ecr[0]});
  endtask

  initial begin
    logic [31:0] words [8];
    logic [63:0] last_res;
    logic        last_ca;
    logic [3:0]  last_cr;
    words[0] = 32'h8000_0000; words[1] = 32'hFFFF_FFFF;
    words[2] = 32'h0000_0000; words[3] = 32'h7FFF_FFFF;
    words[4] = 32'h0000_0001; words[5] = 32'h8000_0001;
    words[6] = 32'hDEAD_BEEF; words[7] = 32'h8000_F000;

    rst_n = 1'b0; in_valid = 1'b0; src_i = '0; amt_i = '0; rec_i = 1'b0; so_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset out_valid", {63'h0, out_valid}, 64'h0);
    chk("R11 reset result", result_o, 64'h0);
    chk("R11 reset flags", {59'h0, ca_o, ca_we_o, cr_we_o, 1'b0},  64'h0);
    chk("R11 reset cond", {60'h0, cr_o}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Full sweep: every amount, every word, clean upper bits, alternating flags.
    for (int i = 0; i < 8; i++) begin
      for (int a = 0; a < 64; a++) begin
        op("sweep", {32'h0, words[i]}, 64'(a), a[0], a[1]);
      end
    end

    // R1/R2: junk in the ignored upper bits of both operands.
    for (int i = 0; i < 8; i++) begin
      for (int a = 0; a < 64; a += 7) begin
        op("R1 R2 junk", {32'hA5C3_0F00 ^ 32'(i * 977), words[i]},
           {58'h2AB_CDEF_1234_5 ^ 58'(a), 6'(a)}, a[1], a[0]);
      end
    end

    // R10: same operation with summary-overflow low and high.
    op("R10 so0", {32'h0, 32'hDEAD_BEEF}, 64'd5, 1'b1, 1'b0);
    op("R10 so1", {32'h0, 32'hDEAD_BEEF}, 64'd5, 1'b1, 1'b1);
    op("R10 norec", {32'h0, 32'h0000_0010}, 64'd3, 1'b0, 1'b1);

    // R9: idle cycle holds values and drops enables.
    last_res = result_o; last_ca = ca_o; last_cr = cr_o;
    in_valid = 1'b0; src_i = 64'hFFFF_FFFF_8000_0001; amt_i = 64'd33; rec_i = 1'b1; so_i = 1'b1;
    @(negedge clk);
    chk("R9 idle out_valid", {63'h0, out_valid}, 64'h0);
    chk("R9 idle result hold", result_o, last_res);
    chk("R9 idle carry hold", {63'h0, ca_o}, {63'h0, last_ca});
    chk("R9 idle cond hold", {60'h0, cr_o}, {60'h0, last_cr});
    chk("R7 idle carry we", {63'h0, ca_we_o}, 64'h0);
    chk("R8 idle cond we", {63'h0, cr_we_o}, 64'h0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule